// File: doc/BRIEF.md
# Vector Mask Test and Merge Unit

This unit owns the 64-bit vector mask of a vector pipeline and carries out the operations that build or consume it. It handles 64-bit elements, one per clock. It can build the mask by testing each element of a vector stream against a sign or zero condition. It can also load the mask straight from a scalar, and the current mask is always visible on an output for readback into a scalar.

The unit consumes the mask in two ways. A masked merge takes an element from the first source where the mask bit is set, and from the second vector where it is clear. The first source is either a broadcast scalar or a second vector stream. A compressed-index operation takes a bit pattern and a 32-bit stride. It emits the position of every set bit, multiplied by the stride, in ascending order.

Operations are started with a one-cycle `start` pulse that carries an opcode, a vector length and the scalar operands. Vector operands arrive on a stream qualified by `elem_valid`. Results leave on a stream qualified by `res_valid`. The unit does not contain the arithmetic units or the register file.

Top module: `vmask_unit`

## Requirements
- R1: After a synchronous reset, `busy`, `res_valid` and `done` are 0, and `mask_out` is all zeros.
- R2: The opcodes 0 (element == 0), 1 (element != 0), 2 (bit 63 clear) and 3 (bit 63 set) test each element taken from `elem_k`. Bit i of the new mask is the result for element i. Bits at or above the vector length are 0. The mask is replaced in the same cycle in which `done` pulses.
- R3: A `vlen` of 0 means 64 elements; any other value gives that many elements. Exactly one element is consumed in each cycle where `busy` and `elem_valid` are both high. Cycles with `elem_valid` low are idle gaps.
- R4: Opcode 4 copies `scal_a` into the mask at the next edge and pulses `done`. It is accepted even while another operation is busy. If it arrives on the same edge as the final commit of a test, the loaded value wins.
- R5: Opcode 5 (scalar merge) produces, for element i, `scal_a` (captured at start) where mask bit i is set, and `elem_k` where it is clear.
- R6: Opcode 6 (vector merge) produces, for element i, `elem_j` where mask bit i is set, and `elem_k` where it is clear.
- R7: A merge uses the mask value held when the merge started. A mask load during the merge changes `mask_out` but not the merge results.
- R8: Opcode 7 (compressed index) takes its bit pattern from `scal_a` and its stride from `stride_in`, and consumes no elements. It emits, in ascending order, position × stride for every set bit below the vector length. The number of outputs equals the popcount of the pattern limited to the vector length, and the mask is not changed.
- R9: Each merge result appears one cycle after its element is consumed. `done` pulses and `busy` falls on the edge that produces the final result, or the final scan step of a compressed index.
- R10: A `start` with any opcode other than 4 while `busy` is high is ignored. The running operation's results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for an operation |
| op | input | 3 | Opcode (0-3 tests, 4 load, 5 scalar merge, 6 vector merge, 7 compressed index) |
| vlen | input | 6 | Vector length, 0 means 64 |
| scal_a | input | 64 | Scalar operand: mask source, broadcast value or index pattern |
| stride_in | input | 32 | Stride for compressed index |
| elem_valid | input | 1 | Element stream valid |
| elem_j | input | 64 | First vector source element |
| elem_k | input | 64 | Second vector source / tested element |
| busy | output | 1 | Multi-cycle operation in progress |
| res_valid | output | 1 | Result element valid |
| res_data | output | 64 | Result element |
| done | output | 1 | Operation completion pulse |
| mask_out | output | 64 | Current mask value |

## Verification
On every cycle, the assertions check several invariants. The mask never changes without a `done` pulse. Test bits are never written at or above the current element index. The element index stays below the length. No result appears unless an operation was running, and the operation context holds still while busy, which is how a start during busy is seen to be ignored. The values themselves can only be shown by the bench's scenarios. These include the actual test outcomes and the clearing above the length, the merge selections, and a mask load in the middle of a merge. They also include index sequences with a maximal stride and empty or truncated patterns.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
    localparam int unsigned VM_ELEMS    = 64;
    localparam int unsigned VM_WORD     = 64;
    localparam int unsigned VM_STRIDE_W = 32;
    localparam int unsigned VM_IDX_W    = $clog2(VM_ELEMS);
    localparam int unsigned VM_CNT_W    = VM_IDX_W + 1;

    typedef enum logic [2:0] {
        OP_TZERO  = 3'd0,
        OP_TNZ    = 3'd1,
        OP_TPOS   = 3'd2,
        OP_TNEG   = 3'd3,
        OP_LDMASK = 3'd4,
        OP_MRG_SV = 3'd5,
        OP_MRG_VV = 3'd6,
        OP_CIDX   = 3'd7
    } vm_op_e;

    typedef struct packed {
        vm_op_e                   op;
        logic [VM_CNT_W-1:0]      len;
        logic [VM_WORD-1:0]       scal;
        logic [VM_STRIDE_W-1:0]   stride;
        logic [VM_ELEMS-1:0]      snap;
    } vm_ctx_t;

    function automatic logic vm_is_test(vm_op_e o);
        return (o == OP_TZERO) || (o == OP_TNZ) || (o == OP_TPOS) || (o == OP_TNEG);
    endfunction

    function automatic logic [VM_CNT_W-1:0] vm_eff_len(logic [VM_IDX_W-1:0] v);
        return (v == '0) ? VM_CNT_W'(VM_ELEMS) : {1'b0, v};
    endfunction

    function automatic logic [VM_ELEMS-1:0] vm_len_mask(logic [VM_CNT_W-1:0] len);
        logic [VM_ELEMS-1:0] m;
        for (int i = 0; i < VM_ELEMS; i++) begin
            m[i] = (i < int'(len));
        end
        return m;
    endfunction
endpackage

// File: rtl/vmask_elem_test.sv
module vmask_elem_test #(
    parameter int unsigned WORD = 64
) (
    input  logic [1:0]      cond,
    input  logic [WORD-1:0] elem,
    output logic            hit
);
    logic is_zero;
    logic sign;

    assign is_zero = (elem == '0);
    assign sign    = elem[WORD-1];

    always_comb begin
        case (cond)
            2'd0:    hit = is_zero;
            2'd1:    hit = !is_zero;
            2'd2:    hit = !sign;
            default: hit = sign;
        endcase
    end
endmodule

// File: rtl/vmask_merge_sel.sv
module vmask_merge_sel #(
    parameter int unsigned WORD = 64
) (
    input  logic            sel,
    input  logic            bcast,
    input  logic [WORD-1:0] scal,
    input  logic [WORD-1:0] first,
    input  logic [WORD-1:0] second,
    output logic [WORD-1:0] out
);
    logic [WORD-1:0] pick;

    assign pick = bcast ? scal : first;
    assign out  = sel ? pick : second;
endmodule

// File: rtl/vmask_cidx_acc.sv
module vmask_cidx_acc #(
    parameter int unsigned ACC_W    = 64,
    parameter int unsigned STRIDE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                step,
    input  logic [STRIDE_W-1:0] stride,
    output logic [ACC_W-1:0]    acc
);
    localparam int unsigned PAD_W = ACC_W - STRIDE_W;

    logic [ACC_W-1:0] stride_ext;
    assign stride_ext = {{PAD_W{1'b0}}, stride};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (step) begin
            acc <= acc + stride_ext;
        end
    end
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
    import vmask_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [2:0]             op,
    input  logic [VM_IDX_W-1:0]    vlen,
    input  logic [VM_WORD-1:0]     scal_a,
    input  logic [VM_STRIDE_W-1:0] stride_in,
    input  logic                   elem_valid,
    input  logic [VM_WORD-1:0]     elem_j,
    input  logic [VM_WORD-1:0]     elem_k,
    output logic                   busy,
    output logic                   res_valid,
    output logic [VM_WORD-1:0]     res_data,
    output logic                   done,
    output logic [VM_ELEMS-1:0]    mask_out
);
    vm_op_e                 op_in;
    vm_ctx_t                ctx_q;
    logic                   busy_q;
    logic [VM_IDX_W-1:0]    idx_q;
    logic [VM_ELEMS-1:0]    mask_q;
    logic [VM_ELEMS-1:0]    build_q;
    logic [VM_ELEMS-1:0]    build_nx;
    logic                   res_valid_q;
    logic [VM_WORD-1:0]     res_data_q;
    logic                   done_q;

    logic                   accept_ld;
    logic                   accept_run;
    logic                   is_cidx;
    logic                   is_tst;
    logic                   step;
    logic                   last;
    logic                   sel_bit;
    logic                   hit;
    logic [VM_WORD-1:0]     mrg;
    logic [VM_WORD-1:0]     acc;
    logic [VM_CNT_W-1:0]    new_len;

    assign op_in      = vm_op_e'(op);
    assign accept_ld  = start && (op_in == OP_LDMASK);
    assign accept_run = start && !busy_q && (op_in != OP_LDMASK);
    assign new_len    = vm_eff_len(vlen);
    assign is_cidx    = (ctx_q.op == OP_CIDX);
    assign is_tst     = vm_is_test(ctx_q.op);
    assign step       = busy_q && (is_cidx || elem_valid);
    assign last       = step && ({1'b0, idx_q} == (ctx_q.len - 1'b1));
    assign sel_bit    = ctx_q.snap[idx_q];

    vmask_elem_test #(.WORD(VM_WORD)) u_test (
        .cond (ctx_q.op[1:0]),
        .elem (elem_k),
        .hit  (hit)
    );

    vmask_merge_sel #(.WORD(VM_WORD)) u_merge (
        .sel    (sel_bit),
        .bcast  (ctx_q.op == OP_MRG_SV),
        .scal   (ctx_q.scal),
        .first  (elem_j),
        .second (elem_k),
        .out    (mrg)
    );

    vmask_cidx_acc #(.ACC_W(VM_WORD), .STRIDE_W(VM_STRIDE_W)) u_cidx (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept_run),
        .step   (step && is_cidx),
        .stride (ctx_q.stride),
        .acc    (acc)
    );

    always_comb begin
        build_nx        = build_q;
        build_nx[idx_q] = hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            ctx_q       <= '0;
            idx_q       <= '0;
            mask_q      <= '0;
            build_q     <= '0;
            res_valid_q <= 1'b0;
            res_data_q  <= '0;
            done_q      <= 1'b0;
        end else begin
            res_valid_q <= 1'b0;
            done_q      <= 1'b0;
            if (step) begin
                idx_q <= idx_q + 1'b1;
                if (is_tst) begin
                    build_q <= build_nx;
                end else if (is_cidx) begin
                    if (sel_bit) begin
                        res_valid_q <= 1'b1;
                        res_data_q  <= acc;
                    end
                end else begin
                    res_valid_q <= 1'b1;
                    res_data_q  <= mrg;
                end
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    if (is_tst) begin
                        mask_q <= build_nx;
                    end
                end
            end
            if (accept_run) begin
                busy_q       <= 1'b1;
                ctx_q.op     <= op_in;
                ctx_q.len    <= new_len;
                ctx_q.scal   <= scal_a;
                ctx_q.stride <= stride_in;
                ctx_q.snap   <= (op_in == OP_CIDX) ? (scal_a & vm_len_mask(new_len)) : mask_q;
                idx_q        <= '0;
                build_q      <= '0;
            end
            if (accept_ld) begin
                mask_q <= scal_a;
                done_q <= 1'b1;
            end
        end
    end

    assign busy      = busy_q;
    assign res_valid = res_valid_q;
    assign res_data  = res_data_q;
    assign done      = done_q;
    assign mask_out  = mask_q;

    // R2, R4: the mask moves only together with a completion pulse
    a_r4_mask_change_has_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(mask_q) |-> done_q);

    // R2: test bits are never written at or past the current element index
    a_r2_build_below_idx: assert property (@(posedge clk) disable iff (rst)
        (busy_q && is_tst) |-> ((build_q >> idx_q) == '0));

    // R3: element index stays inside the vector length
    a_r3_idx_within_len: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> ({1'b0, idx_q} < ctx_q.len));

    // R9: a result can only follow a cycle in which an operation ran
    a_r9_result_needs_busy: assert property (@(posedge clk) disable iff (rst)
        res_valid_q |-> $past(busy_q));

    // R10: a running operation's context is never overwritten
    a_r10_ctx_stable_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(ctx_q));
endmodule

// File: tb/sim_vmask_unit.sv
`timescale 1ns/1ps
module sim_vmask_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [5:0]  vlen = 6'd0;
    logic [63:0] scal_a = '0;
    logic [31:0] stride_in = '0;
    logic        elem_valid = 1'b0;
    logic [63:0] elem_j = '0;
    logic [63:0] elem_k = '0;
    logic        busy, res_valid, done;
    logic [63:0] res_data, mask_out;

    always #2 clk = ~clk;

    vmask_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .vlen(vlen),
        .scal_a(scal_a), .stride_in(stride_in), .elem_valid(elem_valid),
        .elem_j(elem_j), .elem_k(elem_k), .busy(busy), .res_valid(res_valid),
        .res_data(res_data), .done(done), .mask_out(mask_out)
    );

    int          checks = 0;
    int          errors = 0;
    logic [63:0] vj [64];
    logic [63:0] vk [64];
    logic [63:0] got [1024];
    int          got_n = 0;
    logic [63:0] exp_mask = '0;

    always @(negedge clk) begin
        if (res_valid) begin
            got[got_n % 1024] = res_data;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic tbit(input int o, input logic [63:0] x);
        case (o)
            0: return x == 64'd0;
            1: return x != 64'd0;
            2: return !x[63];
            default: return x[63];
        endcase
    endfunction

    function automatic logic [63:0] rand_elem();
        case ($urandom % 4)
            0: return 64'd0;
            1: return {$urandom, $urandom};
            2: return {1'b1, 31'($urandom), $urandom};
            default: return 64'($urandom % 16);
        endcase
    endfunction

    task automatic fill_rand();
        for (int i = 0; i < 64; i++) begin
            vj[i] = rand_elem();
            vk[i] = rand_elem();
        end
    endtask

    // inj_cyc < 0: no extra start during the run
    task automatic run_op(input int opc, input int vl, input logic [63:0] sa, input logic [31:0] sb,
                          input int gap, input int inj_cyc, input int inj_op, input logic [63:0] inj_val,
                          input string req);
        int n, base, e, cyc, t, cnt;
        logic [63:0] snap, m, ex;
        n = (vl == 0) ? 64 : vl;
        base = got_n;
        snap = exp_mask;
        @(negedge clk);
        start = 1'b1; op = 3'(opc); vlen = 6'(vl); scal_a = sa; stride_in = sb;
        @(negedge clk);
        start = 1'b0;
        if (opc == 4) begin
            exp_mask = sa;
            chk(done === 1'b1, {req, " R4 done"}, 64'(done), 64'd1);
            chk(mask_out === sa, {req, " R4 mask"}, mask_out, sa);
            return;
        end
        if (opc != 7) begin
            e = 0; cyc = 0;
            while (e < n) begin
                if (cyc == inj_cyc) begin
                    start = 1'b1; op = 3'(inj_op); scal_a = inj_val;
                end
                elem_valid = (($urandom % 100) >= gap);
                elem_j = vj[e]; elem_k = vk[e];
                @(negedge clk);
                start = 1'b0;
                if (elem_valid) e++;
                cyc++;
            end
            elem_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 300) begin
            @(negedge clk);
            t++;
        end
        chk(done === 1'b1, {req, " R9 done pulse"}, 64'(done), 64'd1);
        chk(busy === 1'b0, {req, " R9 busy drops with done"}, 64'(busy), 64'd0);
        @(negedge clk);
        cnt = got_n - base;
        if (opc <= 3) begin
            m = '0;
            for (int i = 0; i < n; i++) m[i] = tbit(opc, vk[i]);
            exp_mask = m;
            chk(cnt == 0, {req, " R2 no results"}, 64'(cnt), 64'd0);
        end else if (opc == 7) begin
            int k;
            k = 0;
            for (int p = 0; p < n; p++) begin
                if (sa[p]) begin
                    ex = 64'(p) * 64'(sb);
                    if (k < cnt)
                        chk(got[(base + k) % 1024] === ex, {req, " R8 index value"}, got[(base + k) % 1024], ex);
                    k++;
                end
            end
            chk(cnt == k, {req, " R8 output count"}, 64'(cnt), 64'(k));
        end else begin
            chk(cnt == n, {req, " R3 result count"}, 64'(cnt), 64'(n));
            for (int i = 0; i < n && i < cnt; i++) begin
                ex = snap[i] ? ((opc == 5) ? sa : vj[i]) : vk[i];
                chk(got[(base + i) % 1024] === ex,
                    {req, (opc == 5) ? " R5 scalar merge" : " R6 vector merge"}, got[(base + i) % 1024], ex);
            end
            if (inj_cyc >= 0 && inj_op == 4) exp_mask = inj_val;
        end
        chk(mask_out === exp_mask, {req, " mask after op"}, mask_out, exp_mask);
    endtask

    task automatic run_all();
        logic [63:0] pat;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && res_valid === 1'b0 && done === 1'b0, "R1 idle after reset",
            {61'd0, busy, res_valid, done}, 64'd0);
        chk(mask_out === 64'd0, "R1 mask cleared", mask_out, 64'd0);

        // R4: direct load
        run_op(4, 0, 64'hF0F0_0F0F_A5A5_5A5A, 0, 0, -1, 0, 0, "R4 load");

        // R2/R3: zero test over full length (vlen 0 = 64), with gaps
        for (int i = 0; i < 64; i++) begin
            vk[i] = (i % 3 == 0) ? 64'd0 : 64'(i);
            vj[i] = 64'(i) << 8;
        end
        run_op(0, 0, 0, 0, 40, -1, 0, 0, "R2 R3 zero test len64");

        // R2: sign-set test, short length clears the rest
        for (int i = 0; i < 64; i++) vk[i] = 64'h8000_0000_0000_0001;
        run_op(3, 5, 0, 0, 0, -1, 0, 0, "R2 neg test len5");
        chk(mask_out === 64'h1F, "R2 bits above length clear", mask_out, 64'h1F);

        // R7: mask load during a vector merge
        fill_rand();
        run_op(4, 0, 64'hAAAA_5555_FFFF_0000, 0, 0, -1, 0, 0, "R4 load2");
        run_op(6, 20, 0, 0, 20, 6, 4, 64'h0123_4567_89AB_CDEF, "R7 load mid merge");

        // R10: start of another op while busy is ignored
        fill_rand();
        run_op(5, 33, 64'hDEAD_BEEF_0000_1111, 0, 30, 4, 7, 64'hFFFF_FFFF_FFFF_FFFF, "R10 ignored start");

        // R8: compressed index corners
        run_op(7, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 0, -1, 0, 0, "R8 all set max stride");
        run_op(7, 17, 64'd0, 32'd5, 0, -1, 0, 0, "R8 empty pattern");
        run_op(7, 10, 64'h8000_0000_0000_0209, 32'd3, 0, -1, 0, 0, "R8 truncated by length");

        // mixed random operations
        for (int r = 0; r < 60; r++) begin
            int o;
            o = int'($urandom % 8);
            fill_rand();
            pat = {$urandom, $urandom};
            run_op(o, int'($urandom % 64), pat, $urandom, int'($urandom % 50), -1, 0, 0, "random");
        end
    endtask

    initial begin
        process::self().srandom(32'd7);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule